// File: doc/BRIEF.md
# Receiver Offset Auto-Zero Sequencer

This block decides when the input amplifier of a low-frequency receiver is taken off its coil for offset cancellation, and for how long. Each cancellation window lasts a fixed number of oversampling-clock cycles. At 125 kHz, eight cycles is about 64 µs. For the whole window the amplifier input is tied to ground, and the decoded data level is frozen at the value it had just before the window began.

Windows are started by one of two sources. The first is the periodic timebase tick. It is used while the receiver searches for a carrier, and also whenever the decoder is disabled. The second is the decoded-data edge strobe. It is used only while the receiver is in data mode with the decoder enabled. In that case only one edge in four opens a window, so that cancellation stays aligned to data transitions during sync and message reception.

A trigger that arrives while a window is open is dropped. A window that is open when the mode changes always runs to its full length.

Top module: `rx_autozero_seq`

## Requirements
- R1: While reset (`rst_n` low) is sampled at a clock edge, `amp_isolate` and `level_hold` go low after that edge, and the edge counter returns to zero.
- R2: A window start at a clock edge raises `amp_isolate` after that edge. `amp_isolate` then stays high for exactly WIN_LEN (default 8) consecutive cycles.
- R3: `level_hold` is high in exactly the cycles in which `amp_isolate` is high.
- R4: With `data_mode` = 0, a `tb_tick` pulse sampled while no window is open starts a window.
- R5: With `data_mode` = 1 and `dec_en` = 1, ticks are ignored. The 1st, 5th, 9th, ... `edge_stb` pulses counted since entering this state are the window triggers; every edge advances the modulo-EDGE_DIV (default 4) count.
- R6: With `dec_en` = 0, the tick starts windows in either mode and edges have no effect.
- R7: A trigger that arrives while a window is open neither extends that window nor starts a later one.
- R8: Leaving the state `data_mode` = 1 with `dec_en` = 1 clears the edge count. The first edge after re-entry is therefore a trigger.
- R9: A window that is open when `data_mode` or `dec_en` changes keeps its full WIN_LEN length.
- R10: Outside a window, `data_out` equals `data_in`. During a window, `data_out` equals the `data_in` value sampled at the clock edge that opened the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tb_tick | input | 1 | One-cycle pulse per low-frequency timebase period |
| edge_stb | input | 1 | One-cycle pulse per decoded data edge |
| data_mode | input | 1 | 1 = data reception, 0 = carrier search |
| dec_en | input | 1 | Decoder enable; 0 forces tick scheduling |
| data_in | input | 1 | Decoded level from the slicer/decoder |
| amp_isolate | output | 1 | 1 = disconnect amplifier from coil and ground its input |
| level_hold | output | 1 | 1 = decoded level is frozen |
| data_out | output | 1 | Decoded level after hold |

## Verification
The bench goes after four kinds of error:
- Triggers that land inside an open window. A design that queued or restarted on them would show windows longer than WIN_LEN, or a window that starts right after another one.
- Mode switches in the middle of a window. A design that truncated the window on the switch would produce short windows.
- Re-entry into data mode after some edges had already been counted. A design that kept a stale count would miss the first edge.
- Data that changes during a window. A design that sampled the level one cycle late, or did not hold it at all, would let `data_out` move while the window is open.

// File: rtl/az_pkg.sv
// Package: shared types for the auto-zero sequencer.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package az_pkg;
    // Source that currently schedules auto-zero windows.
    typedef enum logic {
        SCHED_TICK = 1'b0,
        SCHED_EDGE = 1'b1
    } sched_e;
endpackage

// File: rtl/az_trigger_sel.sv
// Module: az_trigger_sel
// Picks the window trigger: the timebase tick in carrier mode or with the
// decoder off, otherwise one of every EDGE_DIV decoded data edges.
// Assumes tick and edge strobes are single-cycle pulses in the clk domain.
module az_trigger_sel
    import az_pkg::*;
#(
    parameter int EDGE_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tb_tick,
    input  logic edge_stb,
    input  logic data_mode,
    input  logic dec_en,
    output logic trig
);
    localparam int EW = (EDGE_DIV > 1) ? $clog2(EDGE_DIV) : 1;
    localparam logic [EW-1:0] LAST = EW'(EDGE_DIV - 1);

    sched_e          sched;
    logic [EW-1:0]   ecnt;

    // Select the scheduling source and form the trigger pulse.
    always_comb begin
        sched = (data_mode && dec_en) ? SCHED_EDGE : SCHED_TICK;
        trig  = (sched == SCHED_EDGE) ? (edge_stb && (ecnt == '0)) : tb_tick;
    end

    // Modulo-EDGE_DIV edge counter, cleared outside edge scheduling.
    always_ff @(posedge clk) begin
        if (!rst_n)                    ecnt <= '0;
        else if (sched == SCHED_TICK)  ecnt <= '0;
        else if (edge_stb)             ecnt <= (ecnt == LAST) ? '0 : ecnt + EW'(1);
    end

    // R8
    edge_cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_mode && dec_en) |=> (ecnt == '0));
    // R5
    edge_trig_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && data_mode && dec_en) |-> edge_stb);
    // R6
    tick_trig_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !(data_mode && dec_en)) |-> tb_tick);
endmodule

// File: rtl/az_window_timer.sv
// Module: az_window_timer
// Opens a WIN_LEN-cycle window on a trigger seen while idle; triggers that
// arrive during a window are dropped.
// Assumes WIN_LEN >= 2.
module az_window_timer #(
    parameter int WIN_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic active
);
    localparam int CW = $clog2(WIN_LEN);

    logic [CW-1:0] cnt;
    logic          start;

    // A window opens only from the idle state.
    always_comb start = trig && !active;

    // Window state and remaining-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (active) begin
            if (cnt == '0) active <= 1'b0;
            else           cnt    <= cnt - CW'(1);
        end else if (start) begin
            active <= 1'b1;
            cnt    <= CW'(WIN_LEN - 1);
        end
    end

    // R2
    no_spurious_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !trig) |=> !active);
    // R7
    win_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cnt != '0) |=> (active && cnt == $past(cnt) - CW'(1)));
    // R2
    win_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cnt == '0) |=> !active);
endmodule

// File: rtl/az_level_hold.sv
// Module: az_level_hold
// Passes the decoded level through, freezing it while a window is open.
// Assumes data_in is synchronous to clk.
module az_level_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic data_in,
    output logic data_out
);
    logic held_q;

    // Track the live level whenever no window is open.
    always_ff @(posedge clk) begin
        if (!rst_n)       held_q <= 1'b0;
        else if (!active) held_q <= data_in;
    end

    // Present the held level during a window, the live level otherwise.
    always_comb data_out = active ? held_q : data_in;

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> $stable(data_out));
endmodule

// File: rtl/rx_autozero_seq.sv
// Module: rx_autozero_seq (top)
// Schedules offset-cancellation windows for a low-frequency receiver and
// drives the amplifier isolate and decoded-level hold controls.
// Assumes all inputs are synchronous to clk; reset is synchronous active-low.
module rx_autozero_seq #(
    parameter int WIN_LEN  = 8,
    parameter int EDGE_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tb_tick,
    input  logic edge_stb,
    input  logic data_mode,
    input  logic dec_en,
    input  logic data_in,
    output logic amp_isolate,
    output logic level_hold,
    output logic data_out
);
    logic trig;
    logic active;

    az_trigger_sel #(.EDGE_DIV(EDGE_DIV)) u_trig (
        .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .edge_stb(edge_stb),
        .data_mode(data_mode), .dec_en(dec_en), .trig(trig)
    );

    az_window_timer #(.WIN_LEN(WIN_LEN)) u_timer (
        .clk(clk), .rst_n(rst_n), .trig(trig), .active(active)
    );

    az_level_hold u_hold (
        .clk(clk), .rst_n(rst_n), .active(active),
        .data_in(data_in), .data_out(data_out)
    );

    // Both analog controls follow the window state.
    always_comb begin
        amp_isolate = active;
        level_hold  = active;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!amp_isolate && !level_hold));
    // R3
    hold_iso_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level_hold == amp_isolate);
endmodule

// File: tb/rx_autozero_seq_tb.sv
module rx_autozero_seq_tb;
    localparam int CLK_P    = 8;
    localparam int WIN      = 8;
    localparam int DIV      = 4;
    localparam int WDOG_CYC = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tb_tick = 1'b0, edge_stb = 1'b0, data_mode = 1'b0, dec_en = 1'b1, data_in = 1'b0;
    logic amp_isolate, level_hold, data_out;

    int checks = 0, fails = 0;
    string phase = "R1 reset";
    bit chk_en = 1'b0;
    int run = 0;

    // reference model state
    int m_rem = 0, m_ecnt = 0;
    bit m_held = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    rx_autozero_seq #(.WIN_LEN(WIN), .EDGE_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .edge_stb(edge_stb),
        .data_mode(data_mode), .dec_en(dec_en), .data_in(data_in),
        .amp_isolate(amp_isolate), .level_hold(level_hold), .data_out(data_out)
    );

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        bit trig;
        trig = 1'b0;
        if (!rst_n) begin
            m_rem = 0; m_ecnt = 0; m_held = 1'b0;
        end else begin
            if (data_mode && dec_en) begin
                if (edge_stb) begin
                    if (m_ecnt == 0) trig = 1'b1;
                    m_ecnt = (m_ecnt + 1) % DIV;
                end
            end else begin
                m_ecnt = 0;
                trig = tb_tick;
            end
            if (m_rem == 0) m_held = data_in;
            if (m_rem > 0) m_rem = m_rem - 1;
            else if (trig) m_rem = WIN;
        end
    end

    task automatic check1(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s [%s] act=%0b exp=%0b t=%0t", req, what, phase, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit e_act;
        e_act = (m_rem > 0);
        check1("R2", "amp_isolate", amp_isolate, e_act);
        check1("R3", "level_hold", level_hold, amp_isolate);
        check1("R10", "data_out", data_out, e_act ? m_held : data_in);
        if (amp_isolate === 1'b1) run++;
        else begin
            if (run > 0) begin
                checks++;
                if (run != WIN) begin
                    fails++;
                    $display("FAIL R2 window length [%s] act=%0d exp=%0d", phase, run, WIN);
                end
            end
            run = 0;
        end
    endtask

    // one cycle: compare at the falling edge, then drive new inputs
    task automatic step(input bit tk, input bit ed, input bit din);
        @(negedge clk);
        if (chk_en) compare();
        tb_tick = tk; edge_stb = ed; data_in = din;
    endtask

    task automatic run_mix(input int n, input int tick_per, input int edge_pct);
        for (int i = 0; i < n; i++)
            step((i % tick_per) == 0, ($urandom % 100) < edge_pct, $urandom % 2);
    endtask

    initial begin
        #(CLK_P * WDOG_CYC);
        fails++; checks++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check1("R1", "amp_isolate in reset", amp_isolate, 1'b0);
        check1("R1", "level_hold in reset", level_hold, 1'b0);
        rst_n = 1'b1;
        chk_en = 1'b1;

        // R4: carrier mode, sparse ticks
        phase = "R4 carrier sparse ticks";
        data_mode = 1'b0; dec_en = 1'b1;
        run_mix(300, 20, 30);

        // R7: ticks faster than the window
        phase = "R7 ticks inside window";
        run_mix(300, 3, 30);

        // R5: data mode, edge-aligned every fourth edge
        phase = "R5 data mode edges";
        data_mode = 1'b1; dec_en = 1'b1;
        run_mix(600, 7, 25);
        phase = "R7 dense edges";
        run_mix(300, 5, 80);

        // R6: decoder disabled in data mode
        phase = "R6 decoder off";
        dec_en = 1'b0;
        run_mix(300, 15, 50);

        // R8: partial edge count, leave, return; first edge must trigger
        phase = "R8 counter clear";
        dec_en = 1'b1;
        repeat (12) step(0, 0, 0);
        step(0, 1, 1);
        repeat (12) step(0, 0, 0);
        step(0, 1, 0);
        repeat (3) step(0, 0, 1);
        data_mode = 1'b0;
        repeat (3) step(0, 0, 0);
        data_mode = 1'b1;
        step(0, 1, 1);
        step(0, 0, 1);
        check1("R8", "window after re-entry edge", amp_isolate, 1'b1);
        repeat (12) step(0, 0, 0);

        // R9: mode changes inside an open window
        phase = "R9 mode change mid-window";
        for (int k = 0; k < 20; k++) begin
            data_mode = 1'b0; dec_en = 1'b1;
            step(1, 0, $urandom % 2);
            repeat (2 + (k % 5)) step(0, $urandom % 2, $urandom % 2);
            data_mode = 1'b1;
            if (k % 3 == 0) dec_en = 1'b0;
            repeat (12) step($urandom % 2, $urandom % 2, $urandom % 2);
        end

        // R10: random everything with mode churn
        phase = "R10 mixed churn";
        for (int k = 0; k < 800; k++) begin
            if (k % 37 == 0) data_mode = $urandom % 2;
            if (k % 53 == 0) dec_en = $urandom % 2;
            step(($urandom % 9) == 0, ($urandom % 4) == 0, $urandom % 2);
        end

        step(0, 0, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule